// File: doc/BRIEF.md
# Limb-Serial Multiply-Accumulate Chain

This block multiplies a multi-word unsigned integer by a single word and adds a second multi-word integer, one word (limb) at a time. Each step computes the double-width value `a*b + c + k`, where `a` is the incoming limb, `b` is a multiplier held for the whole chain, `c` is the matching addend limb and `k` is a word-wide carry. The low half of the step leaves the block as a result limb. The high half is kept inside the block and becomes `k` for the next limb. Because `(2^W-1)^2 + 2*(2^W-1) = 2^(2W)-1`, the step result always fits in two words, so the block needs no overflow flag.

The carry is held as a visible state register. The first step of a chain reads it, and the last step writes it back. Software can therefore seed a chain with a nonzero carry, or save the carry after an interrupted chain and resume from it later. Steps in the middle of a chain take the carry only from the internal forwarding register. A chain starts with a one-cycle `start` pulse that carries the limb count and the multiplier. After that, limbs are accepted one at a time with `in_valid` while `in_ready` is high. Each limb goes through a shift-add multiplier that takes W cycles.

Top module: `limbmac_chain`

## Requirements
- R1: For each accepted limb, `res_limb` equals the low W bits of `in_a*mult_b + in_c + k`, where `k` is the carry that enters that step.
- R2: With all of `in_a`, `mult_b`, `in_c` and the carry at 2^W-1, the step gives a result limb of 2^W-1 and an outgoing carry of 2^W-1, with no loss of bits.
- R3: The first limb of a chain uses the value `carry_state` had when `start` was taken. Each later limb uses the high half of the previous step. Result limbs leave lowest limb first, one `res_valid` pulse per limb.
- R4: On the last limb, `carry_valid` pulses in the same cycle as that limb's `res_valid`. `carry_out` then holds the high half of the last step, and `carry_state` holds the same value from the next cycle on. `carry_valid` stays low on all other limbs.
- R5: A `start` with `limb_count` of 0 produces no `res_valid`. In the cycle after the start edge, `carry_valid` is 1 and `carry_out` equals `carry_state`, and `busy` is low again.
- R6: `res_valid` for a limb rises W+1 clock edges after the edge on which the limb was accepted.
- R7: `busy` is high from the start edge of a nonzero chain until its last result. `in_ready` is high only while the block waits for the next limb.
- R8: While `busy` is high, `carry_wr` and `start` have no effect. `carry_state` keeps its value, and the chain runs on with its original multiplier, carry and count.
- R9: After reset, `busy`, `in_ready`, `res_valid` and `carry_valid` are 0 and `carry_state` is 0. When idle, `carry_wr` loads `carry_wdata` into `carry_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a chain (taken only when idle) |
| limb_count | input | CNT_W | Number of limbs in the chain |
| mult_b | input | W | Scalar multiplier for the chain |
| carry_wr | input | 1 | Load the carry state (taken only when idle) |
| carry_wdata | input | W | Value for the carry state |
| in_valid | input | 1 | A limb and its addend are presented |
| in_a | input | W | Multiplicand limb |
| in_c | input | W | Addend limb |
| in_ready | output | 1 | Block is waiting for the next limb |
| busy | output | 1 | A chain is in progress |
| res_valid | output | 1 | One-cycle pulse: `res_limb` is valid |
| res_limb | output | W | Low half of the step result |
| carry_valid | output | 1 | One-cycle pulse: `carry_out` is valid |
| carry_out | output | W | Final carry of the chain |
| carry_state | output | W | Current carry state |

## Verification
The assertions rely on two input rules. `in_valid` counts only while `in_ready` is high. A software write to the carry arriving while a limb is awaited must leave the carry untouched. The stimulus holds `in_valid` for exactly one cycle, and only after it has seen `in_ready`. It also drives stray `carry_wr` and `start` pulses into the waiting and multiplying phases on purpose, so the ignore rules are exercised without breaking the input rules. Expected values come from full double-width arithmetic in the bench. This includes the all-ones operands that bound the shift-add accumulator.

// File: rtl/limbmac_pkg.sv
package limbmac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MUL
  } chain_state_e;
endpackage

// File: rtl/limbmac_mul.sv
// Multicycle shift-add unit: {hi,lo} = a*b + c + d in W cycles.
// Both addends are preloaded into the upper accumulator; their bits
// drain into the low word as the multiplier bits are consumed.
module limbmac_mul #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  output logic         running,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W:0]   hi_q;
  logic [W-1:0] lo_q;
  logic [W-1:0] b_q;
  logic [CW-1:0] cnt_q;
  logic         run_q;
  logic         done_q;
  logic [W+1:0] sum;

  always_comb begin
    sum = {1'b0, hi_q} + (lo_q[0] ? {2'b00, b_q} : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      lo_q   <= '0;
      b_q    <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && !run_q) begin
        hi_q  <= {1'b0, op_c} + {1'b0, op_d};
        lo_q  <= op_a;
        b_q   <= op_b;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        {hi_q, lo_q} <= {sum, lo_q[W-1:1]};
        cnt_q        <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign running = run_q;
  assign done    = done_q;
  assign prod_hi = hi_q[W-1:0];
  assign prod_lo = lo_q;

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !hi_q[W]);

  // R6
  mul_done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(run_q));
endmodule

// File: rtl/limbmac_carry.sv
// Architectural carry register: chain commit has priority over software write.
module limbmac_carry #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_data,
  input  logic         chain_wr,
  input  logic [W-1:0] chain_data,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)           q_r <= '0;
    else if (chain_wr) q_r <= chain_data;
    else if (sw_wr)    q_r <= sw_data;
  end

  assign q = q_r;

  // R4
  carry_commit_chk: assert property (@(posedge clk) disable iff (rst)
    chain_wr |=> (q_r == $past(chain_data)));
endmodule

// File: rtl/limbmac_chain.sv
module limbmac_chain
  import limbmac_pkg::*;
#(
  parameter int W     = 64,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] limb_count,
  input  logic [W-1:0]     mult_b,
  input  logic             carry_wr,
  input  logic [W-1:0]     carry_wdata,
  input  logic             in_valid,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_c,
  output logic             in_ready,
  output logic             busy,
  output logic             res_valid,
  output logic [W-1:0]     res_limb,
  output logic             carry_valid,
  output logic [W-1:0]     carry_out,
  output logic [W-1:0]     carry_state
);
  chain_state_e     state_q;
  logic [CNT_W-1:0] left_q;
  logic [W-1:0]     fwd_q;
  logic [W-1:0]     b_q;
  logic             mul_go, mul_run, mul_done;
  logic [W-1:0]     mul_hi, mul_lo;
  logic             last_step;
  logic             sw_wr;

  assign mul_go    = (state_q == ST_WAIT) && in_valid;
  assign last_step = (state_q == ST_MUL) && mul_done && (left_q == CNT_W'(1));
  assign sw_wr     = carry_wr && (state_q == ST_IDLE) && !start;

  limbmac_mul #(.W(W)) u_mul (
    .clk     (clk),
    .rst     (rst),
    .go      (mul_go),
    .op_a    (in_a),
    .op_b    (b_q),
    .op_c    (in_c),
    .op_d    (fwd_q),
    .running (mul_run),
    .done    (mul_done),
    .prod_hi (mul_hi),
    .prod_lo (mul_lo)
  );

  limbmac_carry #(.W(W)) u_carry (
    .clk        (clk),
    .rst        (rst),
    .sw_wr      (sw_wr),
    .sw_data    (carry_wdata),
    .chain_wr   (last_step),
    .chain_data (mul_hi),
    .q          (carry_state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      left_q      <= '0;
      fwd_q       <= '0;
      b_q         <= '0;
      res_valid   <= 1'b0;
      res_limb    <= '0;
      carry_valid <= 1'b0;
      carry_out   <= '0;
    end else begin
      res_valid   <= 1'b0;
      carry_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            b_q    <= mult_b;
            fwd_q  <= carry_state;
            left_q <= limb_count;
            if (limb_count == '0) begin
              carry_valid <= 1'b1;
              carry_out   <= carry_state;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (in_valid) state_q <= ST_MUL;
        end
        ST_MUL: begin
          if (mul_done) begin
            res_valid <= 1'b1;
            res_limb  <= mul_lo;
            fwd_q     <= mul_hi;
            left_q    <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) begin
              carry_valid <= 1'b1;
              carry_out   <= mul_hi;
              state_q     <= ST_IDLE;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign in_ready = (state_q == ST_WAIT);

  // R7
  result_from_mul_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(state_q == ST_MUL));

  // R7
  mul_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mul_run |-> (state_q == ST_MUL));

  // R8
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_WAIT) && carry_wr) |=> $stable(carry_state));

  // R5
  empty_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (carry_valid && !res_valid) |-> $past((state_q == ST_IDLE) && start));
endmodule

// File: tb/tb_limbmac_chain.sv
module tb_limbmac_chain;
  localparam int W = 64;
  localparam int CNT_W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // each row: {mult_b, carry_in, a, c}
  localparam logic [4*W-1:0] VEC [NV] = '{
    {64'd3, 64'd0, 64'd5, 64'd7},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {64'h1234_5678_9ABC_DEF0, 64'd11, 64'h0FED_CBA9_8765_4321, 64'd0},
    {64'd0, 64'h8000_0000_0000_0000, 64'hDEAD_BEEF_0000_0001, 64'h8000_0000_0000_0000},
    {64'h8000_0000_0000_0001, 64'd1, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_0000_0000},
    {64'd1, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5555_5555_5555_5555}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNT_W-1:0] limb_count = '0;
  logic [W-1:0] mult_b = '0;
  logic carry_wr = 1'b0;
  logic [W-1:0] carry_wdata = '0;
  logic in_valid = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_c = '0;
  logic in_ready, busy, res_valid, carry_valid;
  logic [W-1:0] res_limb, carry_out, carry_state;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  limbmac_chain #(.W(W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .start(start), .limb_count(limb_count),
    .mult_b(mult_b), .carry_wr(carry_wr), .carry_wdata(carry_wdata),
    .in_valid(in_valid), .in_a(in_a), .in_c(in_c), .in_ready(in_ready),
    .busy(busy), .res_valid(res_valid), .res_limb(res_limb),
    .carry_valid(carry_valid), .carry_out(carry_out), .carry_state(carry_state)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] step(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [W-1:0] c, input logic [W-1:0] d);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b} + {{W{1'b0}}, c} + {{W{1'b0}}, d};
  endfunction

  task automatic set_carry(input logic [W-1:0] v);
    @(negedge clk); carry_wr = 1'b1; carry_wdata = v;
    @(negedge clk); carry_wr = 1'b0;
  endtask

  task automatic begin_chain(input int cnt, input logic [W-1:0] b);
    @(negedge clk); start = 1'b1; limb_count = CNT_W'(cnt); mult_b = b;
    @(negedge clk); start = 1'b0; mult_b = '0;
  endtask

  // presents one limb at a negedge where in_ready is expected; returns result data
  task automatic feed(input logic [W-1:0] a, input logic [W-1:0] c,
                      output logic [W-1:0] lo, output logic cv,
                      output logic [W-1:0] co, output int lat);
    chk("R7 in_ready before limb", W'(in_ready), W'(1));
    in_valid = 1'b1; in_a = a; in_c = c;
    @(negedge clk); in_valid = 1'b0; in_a = '0; in_c = '0;
    lat = 0;
    while (!res_valid && lat < 300) begin
      @(negedge clk); lat++;
    end
    lo = res_limb; cv = carry_valid; co = carry_out;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] lo, co, kin;
    logic cv;
    int lat;
    logic [2*W-1:0] full;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 busy", W'(busy), W'(0));
    chk("R9 in_ready", W'(in_ready), W'(0));
    chk("R9 res_valid", W'(res_valid), W'(0));
    chk("R9 carry_valid", W'(carry_valid), W'(0));
    chk("R9 carry_state", carry_state, '0);
    set_carry(64'h0123_4567_89AB_CDEF);
    chk("R9 carry write when idle", carry_state, 64'h0123_4567_89AB_CDEF);

    // table of single-limb chains: R1, R2, R3, R4, R6
    for (int i = 0; i < NV; i++) begin
      set_carry(VEC[i][3*W-1:2*W]);
      begin_chain(1, VEC[i][4*W-1:3*W]);
      chk("R7 busy after start", W'(busy), W'(1));
      full = step(VEC[i][2*W-1:W], VEC[i][4*W-1:3*W], VEC[i][W-1:0], VEC[i][3*W-1:2*W]);
      feed(VEC[i][2*W-1:W], VEC[i][W-1:0], lo, cv, co, lat);
      chk("R1 result limb", lo, full[W-1:0]);
      chk("R6 latency", W'(lat), W'(W + 1));
      chk("R4 carry_valid on last", W'(cv), W'(1));
      chk("R4 carry_out", co, full[2*W-1:W]);
      @(negedge clk);
      chk("R4 carry_state", carry_state, full[2*W-1:W]);
      chk("R7 idle after chain", W'(busy), W'(0));
      if (i == 1) begin
        chk("R2 max lo", lo, {W{1'b1}});
        chk("R2 max carry", co, {W{1'b1}});
      end
    end

    // R3 four-limb chain with seeded carry and forwarding
    kin = 64'hFEDC_BA98_7654_3210;
    set_carry(kin);
    begin_chain(4, 64'h9E37_79B9_7F4A_7C15);
    for (int j = 0; j < 4; j++) begin
      logic [W-1:0] a, c;
      a = 64'hC0FF_EE00_0000_0000 ^ W'(j * 64'h1111_2222_3333);
      c = ~a + W'(j);
      full = step(a, 64'h9E37_79B9_7F4A_7C15, c, kin);
      feed(a, c, lo, cv, co, lat);
      chk("R3 chained limb", lo, full[W-1:0]);
      chk("R4 carry_valid only on last", W'(cv), W'(j == 3));
      kin = full[2*W-1:W];
      if (j == 3) chk("R4 final carry_out", co, kin);
      else chk("R7 busy mid chain", W'(busy), W'(1));
    end
    @(negedge clk);
    chk("R4 carry_state after chain", carry_state, kin);

    // R5 zero-length chain passes the carry through
    set_carry(64'h5A5A_0000_FFFF_1234);
    @(negedge clk); start = 1'b1; limb_count = '0; mult_b = 64'd9;
    @(negedge clk); start = 1'b0;
    chk("R5 carry_valid", W'(carry_valid), W'(1));
    chk("R5 carry_out", carry_out, 64'h5A5A_0000_FFFF_1234);
    chk("R5 no res_valid", W'(res_valid), W'(0));
    chk("R5 not busy", W'(busy), W'(0));

    // R8 carry_wr and start ignored while busy
    set_carry(64'd100);
    begin_chain(1, 64'd7);
    carry_wr = 1'b1; carry_wdata = 64'hBAD0_BAD0_BAD0_BAD0;
    @(negedge clk); carry_wr = 1'b0;
    chk("R8 carry_state held while waiting", carry_state, 64'd100);
    in_valid = 1'b1; in_a = 64'd6; in_c = 64'd1;
    @(negedge clk); in_valid = 1'b0;
    start = 1'b1; limb_count = 8'd3; mult_b = 64'd2;
    carry_wr = 1'b1; carry_wdata = 64'hDEAD;
    @(negedge clk); start = 1'b0; carry_wr = 1'b0;
    chk("R8 carry_state held while multiplying", carry_state, 64'd100);
    lat = 0;
    while (!res_valid && lat < 300) begin @(negedge clk); lat++; end
    chk("R8 result uses original operands", res_limb, 64'd143);
    chk("R8 chain ends after original count", W'(carry_valid), W'(1));
    @(negedge clk);
    chk("R8 idle afterwards", W'(busy), W'(0));
    chk("R8 carry_state", carry_state, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule